// File: doc/BRIEF.md
# Dual-Slope Pulse-Width Modulator with Double-Buffered Compare

This block is a two-channel, phase-correct pulse-width modulator. One shared counter climbs from zero to a selectable ceiling (TOP) and then descends back to zero. It moves one step for each count strobe from an internal clock divider. Channels A and B each compare the count against their own compare value. On a match, each channel sets or clears its output level according to a 2-bit drive mode. The result is a waveform centred on the count minimum.

A compare value written by software is held in a pending register. It is moved into the active compare value only when the counter leaves TOP, so a change in the middle of a period never produces a shortened or doubled pulse. A read of a channel returns the pending value, which is always the value written last. The resolution input selects a ceiling of 255, 511 or 1023, and compare values are masked to that width.

Top module: `dual_slope_pwm`

## Requirements
- R1: On each count strobe the count moves by exactly one. It rises from 0 to TOP, falls back to 0 and repeats, so one period is 2*TOP strobes. Without a strobe the count holds.
- R2: A compare write goes to a pending register. The active compare value takes the pending value only on the strobe that moves the count away from TOP. Matches in between use the old active value.
- R3: `rd_data` returns the pending register of the channel chosen by `rd_sel` (0 = A, 1 = B), i.e. the last value written, from the cycle after the write.
- R4: Mode 2'b10 (non-inverted) clears the level on a match reached by an up step and sets it on a match reached by a down step. At one strobe per clock, a compare value C gives 2*C high clocks per period.
- R5: Mode 2'b11 (inverted) is the complement of mode 2'b10. It gives 2*(TOP-C) high clocks per period.
- R6: A compare value of 0 drives the level low in mode 2'b10 and high in mode 2'b11. A compare value equal to TOP drives it high in mode 2'b10 and low in mode 2'b11. The new level takes effect at the next match.
- R7: Modes 2'b00 and 2'b01 disconnect the channel: its `oe_*` is 0 and its `pwm_*` is 0. Modes 2'b1x set `oe_*` to 1.
- R8: `clk_sel` selects the strobe rate: 3'b000 and 3'b110/3'b111 stop the count; 3'b001 strobes every clock; 3'b010, 3'b011, 3'b100 and 3'b101 strobe once every 8, 64, 256 and 1024 clocks. The level changes only on strobe cycles.
- R9: `res_sel` 2'b00, 2'b01 and 2'b10/2'b11 set TOP to 255, 511 and 1023. Compare values are ANDed with TOP before comparison.
- R10: After reset the count is 0, both levels and enables are 0, and both pending and active compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 3 | Count strobe rate select |
| res_sel | input | 2 | Resolution (TOP) select |
| mode_a | input | 2 | Drive mode of channel A |
| mode_b | input | 2 | Drive mode of channel B |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | Write target: 0 = A, 1 = B |
| wr_data | input | 10 | Compare value to write |
| rd_sel | input | 1 | Readback select: 0 = A, 1 = B |
| rd_data | output | 10 | Pending compare value of the selected channel |
| count_o | output | 10 | Current count |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| oe_a | output | 1 | Channel A output enable |
| oe_b | output | 1 | Channel B output enable |

## Verification
A wrong direction flag or turnaround shows on `count_o` at the next strobe and changes the high time of both channels within one period. A pending value copied at the wrong moment changes the level at a match that falls within the same period as the write. The bench therefore writes halfway up a slope and checks the level at points on both the rising and the falling slope. Errors in the divider or the resolution show as the spacing between count changes or as the peak count, both measured within one period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   typedef enum logic [1:0] {
      DRV_OFF_0  = 2'b00,
      DRV_OFF_1  = 2'b01,
      DRV_NONINV = 2'b10,
      DRV_INV    = 2'b11
   } drive_mode_e;

   localparam int unsigned DIV_LOG_8    = 3;
   localparam int unsigned DIV_LOG_64   = 6;
   localparam int unsigned DIV_LOG_256  = 8;
   localparam int unsigned DIV_LOG_1024 = 10;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned PRE_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);
   import pwm_pkg::*;

   if (PRE_W < DIV_LOG_1024) begin : g_bad_pre_w
      $error("PRE_W too small for the largest division");
   end

   logic [PRE_W-1:0] pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre <= '0;
      else        pre <= pre + 1'b1;
   end

   always_comb begin
      case (sel)
         3'd1:    tick = 1'b1;
         3'd2:    tick = &pre[DIV_LOG_8-1:0];
         3'd3:    tick = &pre[DIV_LOG_64-1:0];
         3'd4:    tick = &pre[DIV_LOG_256-1:0];
         3'd5:    tick = &pre[DIV_LOG_1024-1:0];
         default: tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
   parameter int unsigned CNT_W = 10,
   parameter int unsigned MIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [1:0]       res,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] nxt,
   output logic             step_up,
   output logic             at_top
);
   localparam int unsigned MAX_STEP = CNT_W - MIN_W;

   logic rising;
   logic nxt_rising;
   int unsigned width;

   always_comb begin
      width = MIN_W + ((int'(res) > MAX_STEP) ? MAX_STEP : int'(res));
      top   = {CNT_W{1'b1}} >> (CNT_W - width);
   end

   always_comb begin
      if (rising) begin
         if (cnt >= top) begin
            nxt = cnt - 1'b1; nxt_rising = 1'b0;
         end else begin
            nxt = cnt + 1'b1; nxt_rising = 1'b1;
         end
      end else begin
         if (cnt == '0) begin
            nxt = cnt + 1'b1; nxt_rising = 1'b1;
         end else begin
            nxt = cnt - 1'b1; nxt_rising = 1'b0;
         end
      end
   end

   assign step_up = nxt_rising;
   assign at_top  = tick && rising && (cnt >= top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         rising <= 1'b1;
      end else if (tick) begin
         cnt    <= nxt;
         rising <= nxt_rising;
      end
   end

   // R1: one step per strobe, in either direction
   a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));
   // R1: no strobe, no movement
   a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             at_top,
   input  logic             step_up,
   input  logic [CNT_W-1:0] nxt,
   input  logic [CNT_W-1:0] top,
   input  logic [1:0]       mode,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] pending,
   output logic             pin,
   output logic             oe
);
   import pwm_pkg::*;

   logic [CNT_W-1:0] active;
   logic [CNT_W-1:0] cmp;
   logic             inv;
   logic             lvl;

   assign cmp = (at_top ? pending : active) & top;
   assign inv = (mode == DRV_INV);
   assign oe  = mode[1];
   assign pin = oe & lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= '0;
         active  <= '0;
      end else begin
         if (wr)     pending <= wdata;
         if (at_top) active  <= pending;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= 1'b0;
      end else if (tick && (nxt == cmp)) begin
         if (cmp == '0)       lvl <= inv;
         else if (cmp == top) lvl <= ~inv;
         else                 lvl <= step_up ? inv : ~inv;
      end
   end

   // R2: the active value moves only when the count leaves TOP
   a_r2_latch_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active) |-> $past(at_top));
   // R3: a write is visible in the pending register on the next cycle
   a_r3_pending_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (pending == $past(wdata)));
   // R7: a disconnected channel drives nothing
   a_r7_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[1] |-> (!pin && !oe));
   // R8: the level moves only on strobe cycles
   a_r8_level_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lvl) |-> $past(tick));
endmodule

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm #(
   parameter int unsigned CNT_W = 10,
   parameter int unsigned MIN_W = 8,
   parameter int unsigned PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       clk_sel,
   input  logic [1:0]       res_sel,
   input  logic [1:0]       mode_a,
   input  logic [1:0]       mode_b,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic [CNT_W-1:0] count_o,
   output logic             pwm_a,
   output logic             pwm_b,
   output logic             oe_a,
   output logic             oe_b
);
   localparam int unsigned N_CH = 2;

   if (CNT_W < MIN_W) begin : g_bad_cnt_w
      $error("CNT_W must be at least MIN_W");
   end
   if (CNT_W > MIN_W + 3) begin : g_bad_res_span
      $error("resolution select spans at most four widths");
   end

   logic             tick;
   logic [CNT_W-1:0] top;
   logic [CNT_W-1:0] nxt;
   logic             step_up;
   logic             at_top;

   logic [1:0]       ch_mode [N_CH];
   logic [CNT_W-1:0] ch_pend [N_CH];
   logic             ch_pin  [N_CH];
   logic             ch_oe   [N_CH];

   assign ch_mode[0] = mode_a;
   assign ch_mode[1] = mode_b;

   pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
   );

   pwm_updown_counter #(.CNT_W(CNT_W), .MIN_W(MIN_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .res(res_sel),
      .cnt(count_o), .top(top), .nxt(nxt), .step_up(step_up), .at_top(at_top)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      pwm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick), .at_top(at_top),
         .step_up(step_up), .nxt(nxt), .top(top), .mode(ch_mode[c]),
         .wr(wr_en && (wr_sel == 1'(c))), .wdata(wr_data),
         .pending(ch_pend[c]), .pin(ch_pin[c]), .oe(ch_oe[c])
      );
   end

   assign rd_data = ch_pend[rd_sel];
   assign pwm_a   = ch_pin[0];
   assign pwm_b   = ch_pin[1];
   assign oe_a    = ch_oe[0];
   assign oe_b    = ch_oe[1];
endmodule

// File: tb/test_dual_slope_pwm.sv
module test_dual_slope_pwm;
   localparam int CLK_PERIOD = 10;
   localparam int PERIOD8    = 510;
   localparam int NVEC       = 7;
   // a value, a mode, b value, b mode, expected A high clocks, expected B high clocks
   localparam int VEC [NVEC][6] = '{
      '{100, 2,  50, 3, 200, 410},
      '{  0, 2, 255, 3,   0,   0},
      '{255, 2,   0, 3, 510, 510},
      '{  1, 2, 254, 2,   2, 508},
      '{128, 3, 200, 3, 254, 110},
      '{100, 0, 100, 1,   0,   0},
      '{300, 2, 511, 3,  88,   0}
   };

   logic       clk = 0;
   logic       rst_n = 0;
   logic [2:0] clk_sel = 3'd1;
   logic [1:0] res_sel = 2'd0;
   logic [1:0] mode_a = 2'd0, mode_b = 2'd0;
   logic       wr_en = 0, wr_sel = 0, rd_sel = 0;
   logic [9:0] wr_data = '0;
   logic [9:0] rd_data, count_o;
   logic       pwm_a, pwm_b, oe_a, oe_b;
   int total = 0, bad = 0;
   bit done = 0;

   dual_slope_pwm i_dual_slope_pwm (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .res_sel(res_sel),
      .mode_a(mode_a), .mode_b(mode_b), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .count_o(count_o),
      .pwm_a(pwm_a), .pwm_b(pwm_b), .oe_a(oe_a), .oe_b(oe_b)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cmp(input bit ch, input int val);
      @(negedge clk);
      wr_en = 1; wr_sel = ch; wr_data = 10'(val);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic wait_cnt(input int v);
      do @(negedge clk); while (count_o != 10'(v));
   endtask

   task automatic gap(output int n);
      logic [9:0] prev;
      prev = count_o; n = 0;
      do begin @(negedge clk); n++; end while (count_o == prev);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int ha, hb, mx, n;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 count", count_o, 0);
      check("R10 pwm_a", pwm_a, 0);
      check("R10 oe_b", oe_b, 0);
      check("R10 rd_data", rd_data, 0);
      rst_n = 1;

      // table walk: R4 R5 R6 R7 R9 R3
      for (int i = 0; i < NVEC; i++) begin
         write_cmp(0, VEC[i][0]);
         write_cmp(1, VEC[i][2]);
         mode_a = 2'(VEC[i][1]); mode_b = 2'(VEC[i][3]);
         rd_sel = 0; @(negedge clk);
         check("R3 readback A", rd_data, VEC[i][0]);
         rd_sel = 1; @(negedge clk);
         check("R3 readback B", rd_data, VEC[i][2]);
         repeat (1100) @(negedge clk);
         ha = 0; hb = 0;
         for (int k = 0; k < PERIOD8; k++) begin
            @(negedge clk);
            if (pwm_a) ha++;
            if (pwm_b) hb++;
         end
         check($sformatf("R4/R5/R6/R9 high A vec%0d", i), ha, VEC[i][4]);
         check($sformatf("R4/R5/R6/R9 high B vec%0d", i), hb, VEC[i][5]);
         check($sformatf("R7 oe_a vec%0d", i), oe_a, int'(VEC[i][1] >= 2));
         check($sformatf("R7 oe_b vec%0d", i), oe_b, int'(VEC[i][3] >= 2));
      end

      // R2: write in mid-slope is held until TOP
      write_cmp(0, 100);
      mode_a = 2'b10;
      repeat (1100) @(negedge clk);
      wait_cnt(0);
      wait_cnt(50);
      write_cmp(0, 20);
      rd_sel = 0; #1;
      check("R3 pending readback", rd_data, 20);
      wait_cnt(150);
      check("R2 old value still used up-slope", pwm_a, 0);
      wait_cnt(255);
      wait_cnt(30);
      check("R2 new value used after TOP", pwm_a, 0);
      wait_cnt(10);
      check("R4 set on down match", pwm_a, 1);

      // R9: resolution
      res_sel = 2'd1; mx = 0;
      for (int k = 0; k < 1100; k++) begin
         @(negedge clk); if (count_o > mx) mx = count_o;
      end
      check("R9 peak 9-bit", mx, 511);
      res_sel = 2'd2; mx = 0;
      for (int k = 0; k < 2100; k++) begin
         @(negedge clk); if (count_o > mx) mx = count_o;
      end
      check("R9 peak 10-bit", mx, 1023);
      res_sel = 2'd0;
      repeat (2100) @(negedge clk);

      // R1: single steps at full rate
      begin
         logic [9:0] p; int okc; okc = 1;
         for (int k = 0; k < PERIOD8; k++) begin
            p = count_o; @(negedge clk);
            if (!(count_o == p + 10'd1 || count_o == p - 10'd1)) okc = 0;
         end
         check("R1 step by one", okc, 1);
      end

      // R8: prescale
      clk_sel = 3'd2; gap(n); gap(n);
      check("R8 divide 8", n, 8);
      clk_sel = 3'd3; gap(n); gap(n);
      check("R8 divide 64", n, 64);
      clk_sel = 3'd0; @(negedge clk); mx = count_o;
      repeat (200) @(negedge clk);
      check("R8 stopped 000", count_o, mx);
      clk_sel = 3'd6;
      repeat (200) @(negedge clk);
      check("R8 stopped 110", count_o, mx);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule